// File: doc/BRIEF.md
# Converter Result Byte Pair with Coherent Read Lock

This block presents the most recent 10-bit converter result to a processor as two byte-wide registers. A control bit chooses how the result sits in the 16-bit pair. In right-aligned mode the result is zero-extended, so the two top result bits sit in the high byte. In left-aligned mode the result is pushed to the top of the pair, so the high byte alone gives an 8-bit reading. Every result strobe replaces the stored value, whatever sequencing the upstream converter logic uses.

A processor reads one byte per access. A lock makes the two bytes of one read sequence always belong to the same conversion, and the alignment sets which byte opens the sequence. In right-aligned mode the low byte is read first. In left-aligned mode the high byte is read first. Reading the opening byte captures its partner and holds it until the partner is read. Results that arrive in the meantime are still taken in, and the opening byte keeps following the newest result. So software that only ever reads the low byte in right-aligned mode always sees fresh data.

Top module: `adcres_pair`

## Requirements
- R1: With `align_left`=0 a result v appears as `vis_hi`={6'b0, v[9:8]} and `vis_lo`=v[7:0].
- R2: With `align_left`=1 a result v appears as `vis_hi`=v[9:2] and `vis_lo`={v[1:0], 6'b0}. Unused bits read zero in both modes.
- R3: While no lock is held, a result strobed at clock edge k is visible on both byte outputs from edge k onward, and the newest strobe always wins.
- R4: With `align_left`=0, a read of the low byte (`rd_addr`=0) sets the lock. `vis_hi` then holds the high byte that belongs to the low byte just read, and later results do not change it until the high byte is read.
- R5: With `align_left`=1, a read of the high byte (`rd_addr`=1) sets the lock. `vis_lo` then holds the partner low byte until the low byte is read.
- R6: Reading the held byte returns the held value and releases the lock. The newest result taken in during the lock becomes visible in the held byte after that same edge.
- R7: While locked, the opening byte keeps following the newest result. Reading it again restarts the sequence and captures the new partner. This keeps repeated reads of one byte fresh and coherent.
- R8: A change of `align_left` clears the lock, and both bytes are reformatted in the new mode at that edge.
- R9: A synchronous active-high `rst` clears both bytes, the read data, the lock and the stored result.
- R10: `rd_data` is loaded on an edge with `rd_en`=1 with the byte visible just before that edge (`rd_addr`=0 low, 1 high), and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_vld | input | 1 | New conversion result strobe |
| res_data | input | 10 | Conversion result |
| align_left | input | 1 | 1 = left-aligned, 0 = right-aligned |
| rd_en | input | 1 | Byte read strobe |
| rd_addr | input | 1 | Byte select: 0 low, 1 high |
| rd_data | output | 8 | Registered read data |
| vis_hi | output | 8 | Visible high byte register |
| vis_lo | output | 8 | Visible low byte register |

## Verification
The embedded assertions watch, on every cycle, that unused bit positions stay zero in the current mode and that the held byte does not move while a lock is held and no access occurs. They also check that an alignment change always drops the lock and that the read data follows the selected byte or holds. Only the bench's scenarios can show the rest, because those properties span sequences of accesses. They are: a read pair spanning several new results returns bytes of one conversion, the newest pending result appears after release, repeated low-only reads stay fresh, and reset drops a held lock.

// File: rtl/adcres_pkg.sv
package adcres_pkg;
  typedef enum logic {
    BYTE_LO = 1'b0,
    BYTE_HI = 1'b1
  } byte_sel_e;
endpackage

// File: rtl/adcres_fmt.sv
module adcres_fmt #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic [RES_W-1:0]  res,
  input  logic              left,
  output logic [BYTE_W-1:0] hi,
  output logic [BYTE_W-1:0] lo
);
  localparam int PAIR_W = 2 * BYTE_W;
  localparam int PAD_W  = PAIR_W - RES_W;

  logic [PAIR_W-1:0] pair_r;
  logic [PAIR_W-1:0] pair;

  always_comb begin
    pair_r = PAIR_W'(res);
    pair   = left ? (pair_r << PAD_W) : pair_r;
    hi     = pair[PAIR_W-1:BYTE_W];
    lo     = pair[BYTE_W-1:0];
  end
endmodule

// File: rtl/adcres_lock.sv
module adcres_lock
  import adcres_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_q,
  input  logic              mode_chg,
  input  logic              rd_en,
  input  byte_sel_e         rd_sel,
  input  logic [BYTE_W-1:0] partner,
  output logic              lock_q,
  output logic              lock_nxt,
  output logic [BYTE_W-1:0] frozen_nxt
);
  byte_sel_e         open_sel;
  logic              open_rd;
  logic              close_rd;
  logic [BYTE_W-1:0] frozen_q;

  always_comb begin
    open_sel   = mode_q ? BYTE_HI : BYTE_LO;
    open_rd    = rd_en && (rd_sel == open_sel);
    close_rd   = rd_en && (rd_sel != open_sel);
    frozen_nxt = open_rd ? partner : frozen_q;
    if (mode_chg)      lock_nxt = 1'b0;
    else if (open_rd)  lock_nxt = 1'b1;
    else if (close_rd) lock_nxt = 1'b0;
    else               lock_nxt = lock_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q   <= 1'b0;
      frozen_q <= '0;
    end else begin
      lock_q   <= lock_nxt;
      frozen_q <= frozen_nxt;
    end
  end

  // R8
  mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> !lock_q);

  // R6
  close_release_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_q && close_rd) |=> !lock_q);
endmodule

// File: rtl/adcres_rdport.sv
module adcres_rdport
  import adcres_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  byte_sel_e         rd_sel,
  input  logic [BYTE_W-1:0] src_hi,
  input  logic [BYTE_W-1:0] src_lo,
  output logic [BYTE_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= (rd_sel == BYTE_HI) ? src_hi : src_lo;
  end

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  // R10
  rd_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_sel == BYTE_HI) |=> rd_data == $past(src_hi));
endmodule

// File: rtl/adcres_pair.sv
module adcres_pair
  import adcres_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_vld,
  input  logic [RES_W-1:0]  res_data,
  input  logic              align_left,
  input  logic              rd_en,
  input  logic              rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] vis_hi,
  output logic [BYTE_W-1:0] vis_lo
);
  localparam int PAD_W = 2 * BYTE_W - RES_W;

  logic [RES_W-1:0]  latest_q;
  logic [RES_W-1:0]  newest;
  logic              align_q;
  logic              mode_chg;
  byte_sel_e         rd_sel;
  logic [BYTE_W-1:0] nxt_hi, nxt_lo;
  logic [BYTE_W-1:0] cur_hi, cur_lo;
  logic [BYTE_W-1:0] partner;
  logic              lock_q, lock_nxt;
  logic [BYTE_W-1:0] frozen_nxt;
  logic [BYTE_W-1:0] vis_hi_q, vis_lo_q;

  always_comb begin
    newest   = res_vld ? res_data : latest_q;
    mode_chg = (align_left != align_q);
    rd_sel   = byte_sel_e'(rd_addr);
    partner  = align_q ? cur_lo : cur_hi;
  end

  adcres_fmt #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_fmt_nxt (
    .res(newest), .left(align_left), .hi(nxt_hi), .lo(nxt_lo));

  adcres_fmt #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_fmt_cur (
    .res(latest_q), .left(align_q), .hi(cur_hi), .lo(cur_lo));

  adcres_lock #(.BYTE_W(BYTE_W)) u_lock (
    .clk(clk), .rst(rst), .mode_q(align_q), .mode_chg(mode_chg),
    .rd_en(rd_en), .rd_sel(rd_sel), .partner(partner),
    .lock_q(lock_q), .lock_nxt(lock_nxt), .frozen_nxt(frozen_nxt));

  adcres_rdport #(.BYTE_W(BYTE_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_sel(rd_sel),
    .src_hi(vis_hi_q), .src_lo(vis_lo_q), .rd_data(rd_data));

  always_ff @(posedge clk) begin
    if (rst) begin
      latest_q <= '0;
      align_q  <= 1'b0;
      vis_hi_q <= '0;
      vis_lo_q <= '0;
    end else begin
      latest_q <= newest;
      align_q  <= align_left;
      if (align_left) begin
        vis_hi_q <= nxt_hi;
        vis_lo_q <= lock_nxt ? frozen_nxt : nxt_lo;
      end else begin
        vis_lo_q <= nxt_lo;
        vis_hi_q <= lock_nxt ? frozen_nxt : nxt_hi;
      end
    end
  end

  assign vis_hi = vis_hi_q;
  assign vis_lo = vis_lo_q;

  // R1
  right_pad_chk: assert property (@(posedge clk) disable iff (rst)
    !align_q |-> vis_hi_q[BYTE_W-1:RES_W-BYTE_W] == '0);

  // R2
  left_pad_chk: assert property (@(posedge clk) disable iff (rst)
    align_q |-> vis_lo_q[PAD_W-1:0] == '0);

  // R4
  hi_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_q && !align_q && !align_left && !rd_en) |=> $stable(vis_hi_q));

  // R5
  lo_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_q && align_q && align_left && !rd_en) |=> $stable(vis_lo_q));

  // R7
  open_track_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_chg && !align_left && res_vld) |=> vis_lo_q == $past(res_data[BYTE_W-1:0]));
endmodule

// File: tb/adcres_pair_tb.sv
module adcres_pair_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       res_vld;
  logic [9:0] res_data;
  logic       align_left;
  logic       rd_en;
  logic       rd_addr;
  logic [7:0] rd_data, vis_hi, vis_lo;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  int m_latest, m_frozen, m_hi, m_lo, m_rd;
  bit m_mode, m_lock;

  always #2.5 clk = ~clk;

  adcres_pair dut_i (
    .clk(clk), .rst(rst), .res_vld(res_vld), .res_data(res_data),
    .align_left(align_left), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .vis_hi(vis_hi), .vis_lo(vis_lo));

  function automatic int f_hi(int v, bit left);
    return left ? ((v >> 2) & 255) : ((v >> 8) & 3);
  endfunction

  function automatic int f_lo(int v, bit left);
    return left ? ((v & 3) << 6) : (v & 255);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_latest = 0; m_frozen = 0; m_hi = 0; m_lo = 0; m_rd = 0;
    m_mode = 1'b0; m_lock = 1'b0;
  endtask

  task automatic step(input bit vld, input int data, input bit left,
                      input bit rd, input bit addr, input string tag);
    bit first, second;
    @(negedge clk);
    res_vld = vld; res_data = data[9:0]; align_left = left;
    rd_en = rd; rd_addr = addr;
    @(posedge clk);
    #1;
    first  = rd && (addr == m_mode);
    second = rd && (addr != m_mode);
    if (rd) m_rd = addr ? m_hi : m_lo;
    if (first) m_frozen = m_mode ? f_lo(m_latest, 1'b1) : f_hi(m_latest, 1'b0);
    if (vld) m_latest = data & 1023;
    if (left != m_mode) m_lock = 1'b0;
    else if (first)     m_lock = 1'b1;
    else if (second)    m_lock = 1'b0;
    m_mode = left;
    m_hi = f_hi(m_latest, m_mode);
    m_lo = f_lo(m_latest, m_mode);
    if (m_lock) begin
      if (m_mode) m_lo = m_frozen;
      else        m_hi = m_frozen;
    end
    chk(tag, "vis_hi", vis_hi, m_hi);
    chk(tag, "vis_lo", vis_lo, m_lo);
    chk(tag, "rd_data", rd_data, m_rd);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; res_vld = 1'b0; rd_en = 1'b0; align_left = 1'b0;
    res_data = '0; rd_addr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<100000 cycles", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; res_vld = 1'b0; res_data = '0; align_left = 1'b0;
    rd_en = 1'b0; rd_addr = 1'b0;
    model_reset();
    do_reset();

    // R9: reset state
    chk("R9", "vis_hi", vis_hi, 0);
    chk("R9", "vis_lo", vis_lo, 0);
    chk("R9", "rd_data", rd_data, 0);

    // R1: right-aligned formatting, explicit value
    step(1, 10'h2A5, 0, 0, 0, "R1");
    chk("R1", "hi const", vis_hi, 8'h02);
    chk("R1", "lo const", vis_lo, 8'hA5);
    // R3: newest result wins, several patterns
    step(1, 10'h3FF, 0, 0, 0, "R3");
    step(1, 10'h100, 0, 0, 0, "R3");
    step(0, 0,       0, 0, 0, "R3");
    step(1, 10'h0FF, 0, 0, 0, "R3");

    // R10: unlocked reads of each byte, then hold
    step(0, 0, 0, 1, 1, "R10");
    step(0, 0, 0, 0, 0, "R10");
    step(1, 10'h155, 0, 0, 0, "R10");

    // R4: right mode, low read locks high across new results
    step(0, 0,       0, 1, 0, "R4");
    step(1, 10'h2CC, 0, 0, 0, "R4");
    step(1, 10'h3F0, 0, 0, 0, "R4");
    chk("R4", "hi frozen", vis_hi, 8'h01);
    // R6: high read returns held byte, newest appears
    step(0, 0, 0, 1, 1, "R6");
    chk("R6", "rd old hi", rd_data, 8'h01);
    chk("R6", "hi newest", vis_hi, 8'h03);
    step(1, 10'h001, 0, 1, 1, "R6");

    // R7: low-only reads stay fresh and recapture partner
    step(0, 0,       0, 1, 0, "R7");
    step(1, 10'h1AB, 0, 0, 0, "R7");
    step(0, 0,       0, 1, 0, "R7");
    chk("R7", "fresh low", rd_data, 8'hAB);
    step(1, 10'h222, 0, 0, 0, "R7");
    step(1, 10'h323, 0, 1, 0, "R7");
    step(0, 0,       0, 1, 1, "R7");
    chk("R7", "coherent hi", rd_data, 8'h02);

    // R2: left-aligned formatting
    step(1, 10'h2A5, 1, 0, 0, "R2");
    chk("R2", "hi const", vis_hi, 8'hA9);
    chk("R2", "lo const", vis_lo, 8'h40);
    step(1, 10'h3FF, 1, 0, 0, "R2");

    // R5: left mode, high read locks low
    step(0, 0,       1, 1, 1, "R5");
    step(1, 10'h002, 1, 0, 0, "R5");
    step(1, 10'h001, 1, 0, 0, "R5");
    chk("R5", "lo frozen", vis_lo, 8'hC0);
    step(0, 0,       1, 1, 0, "R5");
    chk("R5", "rd old lo", rd_data, 8'hC0);
    chk("R6", "lo newest", vis_lo, 8'h40);

    // R8: alignment change drops a held lock
    step(0, 0,       1, 1, 1, "R8");
    step(1, 10'h1C3, 1, 0, 0, "R8");
    step(1, 10'h2C2, 0, 0, 0, "R8");
    chk("R8", "hi reformatted", vis_hi, 8'h02);
    step(1, 10'h0F1, 1, 0, 0, "R8");
    step(0, 0,       1, 1, 0, "R8");

    // mixed pattern sweep compared every clock
    for (int i = 0; i < 200; i++) begin
      step((i % 3) != 0, (i * 37 + 5) & 1023, (i / 50) % 2 == 1,
           (i % 4) != 1, (i % 5) < 2, "R3");
    end

    // R9: reset while a lock is held
    step(1, 10'h3A7, 0, 1, 0, "R9");
    step(1, 10'h111, 0, 0, 0, "R9");
    do_reset();
    chk("R9", "vis_hi after lock", vis_hi, 0);
    chk("R9", "vis_lo after lock", vis_lo, 0);
    chk("R9", "rd_data after lock", rd_data, 0);
    step(1, 10'h1FE, 0, 0, 0, "R9");
    step(0, 0,       0, 1, 1, "R9");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule